// File: doc/BRIEF.md
# Watchdog Timer with Reset or Power-Off Action

The block is a watchdog counter with a two-word memory-mapped window. Software programs a timeout in whole seconds and sets the run bit. It then keeps writing the restart bit often enough that the countdown never reaches zero. A prescaler turns the core clock into a one-second tick. If the countdown runs out, the block raises a pulse on one of two request outputs: system reset or power-off. A control bit selects which one. The block also sets a sticky flag so that software can tell, after the restart, that the watchdog caused it.

Two configuration inputs gate the block. One enables the watchdog function. The other enables the register window. A separate system-reset input clears the control state but leaves the expiry flag and any request pulse that is already running untouched. Only the power-on reset clears those.

Top module: `wdog_ctrl`

## Requirements
- R1: After power-on reset, word 0 reads 0 while the watchdog is enabled. Word 4 reads the default timeout, 60. Both request outputs are low.
- R2: Word 4 keeps bits [9:0] of a write, and its bits [31:10] read 0. A written value of 0 is stored as 1.
- R3: Writing 1 to bit 7 of word 0 restarts the countdown from the value in word 4. Bit 7 always reads 0.
- R4: Take the restart write as edge 0. With bit 0 (run) set, the expiry action begins at edge T×CLK_PER_SEC and lasts PULSE_CYCLES cycles. With bit 2 at 0, that action is a pulse on reset_req_o.
- R5: With bit 2 of word 0 at 1, the expiry pulse appears on poweroff_req_o instead. The two request outputs are never high together.
- R6: After an expiry, the countdown stays stopped and gives no further pulse until the next restart write.
- R7: A restart write before expiry postpones the expiry to a full timeout after that write.
- R8: While run (bit 0) is 0, the countdown and the prescaler hold their state. Setting run again resumes from where they stopped.
- R9: Bit 1 of word 0 becomes 1 on expiry and survives sys_rst_ni. Writing 1 to bit 1 clears it, writing 0 leaves it, and power-on reset clears it.
- R10: While cfg_en_i is 0, bit 3 of word 0 reads 1 and the countdown is frozen.
- R11: While cfg_win_en_i is 0, rdata_o is 0 and writes have no effect. Accesses with addr_i[1:0] other than 0 are ignored in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low; clears control state only |
| cfg_en_i | input | 1 | Watchdog function enable |
| cfg_win_en_i | input | 1 | Register window enable |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 3 | Byte offset in the window (0 or 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| reset_req_o | output | 1 | System-reset request pulse |
| poweroff_req_o | output | 1 | Power-off request pulse |

## Verification
On every cycle the assertions check four things: the two request outputs are never high together, the restart bit reads 0, the disabled bit follows cfg_en_i, and the closed window reads 0. They also check that the stored timeout is never zero and that the expiry flag is set whenever a request pulse starts. The exact expiry edge, the pulse length, the postponement by a restart, and resuming after a stop can only be shown by the bench's scenarios. The same holds for the flag surviving a system reset and for writes being ignored while the window is closed. The bench counts edges from each write to check these.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int TMO_W     = 10;
  localparam int RUN_BIT   = 0;
  localparam int FIRED_BIT = 1;
  localparam int ACT_BIT   = 2;
  localparam int DIS_BIT   = 3;
  localparam int TRIG_BIT  = 7;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int CLK_PER_SEC = 250_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_SEC - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = en_i & ~clr_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         armed_o,
  output logic         expire_o
);
  logic [W-1:0] rem_q;
  logic         armed_q;

  assign armed_o  = armed_q;
  assign expire_o = tick_i & armed_q & (rem_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      rem_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (tick_i && armed_q) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == W'(1)) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic sel_pwr_i,
  output logic reset_o,
  output logic poweroff_o
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          pwr_q;
  logic          busy;

  assign busy       = (cnt_q != '0);
  assign reset_o    = busy & ~pwr_q;
  assign poweroff_o = busy & pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwr_q <= 1'b0;
    end else if (fire_i) begin
      cnt_q <= CW'(PULSE_CYCLES);
      pwr_q <= sel_pwr_i;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CLK_PER_SEC  = 250_000_000,
  parameter int PULSE_CYCLES = 64,
  parameter int DEF_TIMEOUT  = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sys_rst_ni,
  input  logic        cfg_en_i,
  input  logic        cfg_win_en_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        reset_req_o,
  output logic        poweroff_req_o
);
  logic             ctl_rst_n;
  logic             aligned, wr_ok, wr_ctl, wr_tmo, trig;
  logic             run_q, act_q, fired_q;
  logic [TMO_W-1:0] timeout_q, tmo_wr;
  logic             armed, count_en, tick, expire;
  logic             unused_wdata;

  // control state follows both resets; fired flag and pulse only power-on
  assign ctl_rst_n = rst_ni & sys_rst_ni;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_ok   = req_i & we_i & cfg_win_en_i & aligned;
  assign wr_ctl  = wr_ok & ~addr_i[2];
  assign wr_tmo  = wr_ok & addr_i[2];
  assign trig    = wr_ctl & wdata_i[TRIG_BIT];
  assign tmo_wr  = (wdata_i[TMO_W-1:0] == '0) ? TMO_W'(1) : wdata_i[TMO_W-1:0];

  assign unused_wdata = ^{wdata_i[31:TMO_W]};

  always_ff @(posedge clk_i or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      run_q     <= 1'b0;
      act_q     <= 1'b0;
      timeout_q <= TMO_W'(DEF_TIMEOUT);
    end else begin
      if (wr_ctl) begin
        run_q <= wdata_i[RUN_BIT];
        act_q <= wdata_i[ACT_BIT];
      end
      if (wr_tmo) timeout_q <= tmo_wr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         fired_q <= 1'b0;
    else if (expire)                     fired_q <= 1'b1;
    else if (wr_ctl && wdata_i[FIRED_BIT]) fired_q <= 1'b0;
  end

  assign count_en = run_q & cfg_en_i & armed;

  wdog_prescaler #(.CLK_PER_SEC(CLK_PER_SEC)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (ctl_rst_n),
    .clr_i  (trig),
    .en_i   (count_en),
    .tick_o (tick)
  );

  wdog_countdown #(.W(TMO_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (ctl_rst_n),
    .load_i     (trig),
    .load_val_i (timeout_q),
    .tick_i     (tick),
    .armed_o    (armed),
    .expire_o   (expire)
  );

  wdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (expire),
    .sel_pwr_i  (act_q),
    .reset_o    (reset_req_o),
    .poweroff_o (poweroff_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (cfg_win_en_i && aligned) begin
      if (addr_i[2]) begin
        rdata_o[TMO_W-1:0] = timeout_q;
      end else begin
        rdata_o[RUN_BIT]   = run_q;
        rdata_o[FIRED_BIT] = fired_q;
        rdata_o[ACT_BIT]   = act_q;
        rdata_o[DIS_BIT]   = ~cfg_en_i;
      end
    end
  end
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_en_i,
  input logic        cfg_win_en_i,
  input logic [2:0]  addr_i,
  input logic [31:0] rdata_o,
  input logic        reset_req_o,
  input logic        poweroff_req_o,
  input logic        fired_q,
  input logic [9:0]  timeout_q
);
  p_excl_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reset_req_o && poweroff_req_o));

  p_trig_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_win_en_i && addr_i == 3'd0) |-> (rdata_o[7] == 1'b0));

  p_dis_bit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_win_en_i && addr_i == 3'd0) |-> (rdata_o[3] == !cfg_en_i));

  p_win_closed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_win_en_i |-> (rdata_o == 32'd0));

  p_tmo_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_q != 10'd0);

  p_fired_on_expiry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_req_o || poweroff_req_o) |-> fired_q);
endmodule

bind wdog_ctrl wdog_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_en_i       (cfg_en_i),
  .cfg_win_en_i   (cfg_win_en_i),
  .addr_i         (addr_i),
  .rdata_o        (rdata_o),
  .reset_req_o    (reset_req_o),
  .poweroff_req_o (poweroff_req_o),
  .fired_q        (fired_q),
  .timeout_q      (timeout_q)
);

// File: tb/wdog_ctrl_tb.sv
`timescale 1ns/1ps
module wdog_ctrl_tb;
  localparam int CPS   = 4;
  localparam int PULSE = 5;
  localparam int T     = 2;
  localparam int FIRE  = T * CPS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, sys_rst_n = 1'b1;
  logic        cfg_en = 1'b1, win_en = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rst_req, pwr_req;

  int total = 0, fails = 0;

  always #2 clk = ~clk;

  wdog_ctrl #(.CLK_PER_SEC(CPS), .PULSE_CYCLES(PULSE), .DEF_TIMEOUT(60)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_rst_n), .cfg_en_i(cfg_en),
    .cfg_win_en_i(win_en), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .reset_req_o(rst_req), .poweroff_req_o(pwr_req)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string r);
    addr = a;
    #1;
    chk(rdata === exp, r, rdata, exp);
  endtask

  task automatic expect_quiet(input int n, input string r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!rst_req && !pwr_req, r, {rst_req, pwr_req}, 0);
    end
  endtask

  // fires at the k-th negedge from now, then must last PULSE cycles
  task automatic expect_fire(input int k, input bit pwr, input string r);
    expect_quiet(k - 1, r);
    for (int i = 0; i < PULSE; i++) begin
      @(negedge clk);
      chk(rst_req == !pwr && pwr_req == pwr, r, {rst_req, pwr_req}, {!pwr, pwr});
    end
    @(negedge clk);
    chk(!rst_req && !pwr_req, r, {rst_req, pwr_req}, 0);
  endtask

  task automatic t_reset;
    rd_chk(3'd0, 32'h0, "R1 ctrl");
    rd_chk(3'd4, 32'd60, "R1 timeout");
    chk(!rst_req && !pwr_req, "R1 outputs", {rst_req, pwr_req}, 0);
  endtask

  task automatic t_timeout_reg;
    wr(3'd4, 32'hFFFF_F007);
    rd_chk(3'd4, 32'h7, "R2 upper bits dropped");
    wr(3'd4, 32'h0);
    rd_chk(3'd4, 32'h1, "R2 zero stored as one");
    wr(3'd4, 32'h3FF);
    rd_chk(3'd4, 32'h3FF, "R2 max");
    wr(3'd4, T);
  endtask

  task automatic t_expire_reset;
    wr(3'd0, 32'h81);
    rd_chk(3'd0, 32'h01, "R3 trigger reads 0");
    expect_fire(FIRE, 1'b0, "R4 reset pulse");
    rd_chk(3'd0, 32'h03, "R9 fired set");
    expect_quiet(40, "R6 stopped after expiry");
  endtask

  task automatic t_sys_reset;
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    rd_chk(3'd0, 32'h02, "R9 fired survives sys reset");
    wr(3'd0, 32'h0);
    rd_chk(3'd0, 32'h02, "R9 write 0 keeps fired");
    wr(3'd0, 32'h2);
    rd_chk(3'd0, 32'h00, "R9 write 1 clears fired");
    wr(3'd4, T);
  endtask

  task automatic t_poweroff;
    wr(3'd0, 32'h85);
    expect_fire(FIRE, 1'b1, "R5 poweroff pulse");
    rd_chk(3'd0, 32'h07, "R5 fired with poweroff");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk(3'd0, 32'h00, "R9 power-on clears fired");
    wr(3'd4, T);
  endtask

  task automatic t_retrigger;
    wr(3'd0, 32'h81);
    expect_quiet(5, "R7 before retrigger");
    wr(3'd0, 32'h81);
    expect_fire(FIRE, 1'b0, "R7 postponed expiry");
  endtask

  task automatic t_stop_resume;
    wr(3'd0, 32'h81);
    expect_quiet(3, "R8 counting");
    wr(3'd0, 32'h00);
    expect_quiet(30, "R8 stopped");
    wr(3'd0, 32'h01);
    expect_fire(3, 1'b0, "R8 resume remaining");
  endtask

  task automatic t_cfg_disable;
    @(negedge clk); cfg_en = 1'b0;
    wr(3'd0, 32'h83);
    rd_chk(3'd0, 32'h09, "R10 disabled bit");
    expect_quiet(30, "R10 frozen");
    cfg_en = 1'b1;
    expect_fire(FIRE, 1'b0, "R10 counts after enable");
  endtask

  task automatic t_window;
    @(negedge clk); win_en = 1'b0;
    rd_chk(3'd4, 32'h0, "R11 closed read");
    wr(3'd4, 32'd9);
    wr(3'd0, 32'h81);
    expect_quiet(20, "R11 trigger ignored");
    win_en = 1'b1;
    rd_chk(3'd4, T, "R11 timeout unchanged");
    wr(3'd5, 32'h81);
    expect_quiet(20, "R11 unaligned ignored");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timeout_reg();
    t_expire_reset();
    t_sys_reset();
    t_poweroff();
    t_retrigger();
    t_stop_resume();
    t_cfg_disable();
    t_window();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule